// File: doc/BRIEF.md
# Wiper Control Input Debouncer

This block cleans up four slow, bouncy control inputs of an interval wiper controller: the interval switch, the wash button, the park contact and the over-current flag. Every raw level first crosses a two-stage synchroniser into the system clock domain. A per-channel counter then waits for the synchronised level to stay away from the channel's clean level for a set number of coarse ticks before it takes the new level.

Coarse ticks come from one free-running prescaler. The prescaler advances on an enable strobe that marks each oscillator cycle. A channel's counter starts at an arbitrary phase of its prescaler tap, so its acceptance time is a window of oscillator cycles rather than one exact value. The wash channel has a long window for a press and a short window for a release. For each channel the block gives a clean level and a one-cycle pulse on every accepted change. The sequencing logic downstream reads both.

Top module: `wiperDebounceTop`

## Requirements
- R1: While reset is asserted, every clean level and every change pulse is 0.
- R2: Each raw input passes through two flip-flop stages before the counting logic sees it. Window counting therefore starts at the second clock edge after the raw change, and a clean level only ever takes a value the raw input held three edges earlier.
- R3: Interval switch (bit 0): a change is accepted no earlier than the 25th and no later than the 32nd oscillator cycle of stable input.
- R4: Wash button press (bit 1, 0 to 1): accepted between the 113th and the 128th oscillator cycle of stable input.
- R5: Wash button release (bit 1, 1 to 0): accepted between the 17th and the 32nd oscillator cycle of stable input.
- R6: Park contact (bit 2): a change is accepted at the 7th or 8th oscillator cycle of stable input.
- R7: Over-current flag (bit 3): a change is accepted at exactly the 3rd oscillator cycle of stable input.
- R8: If the synchronised input returns to the clean level before acceptance, all progress is discarded. The next attempt needs a full window again.
- R9: A channel's change pulse is high for exactly the one clock cycle after an edge at which its clean level changed, and never at any other time.
- R10: Only clock edges with the oscillator strobe high advance a count. With the strobe held low, no clean level changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscTick | input | 1 | One-cycle strobe per oscillator cycle |
| rawIn | input | 4 | Raw active-high levels: bit 0 interval switch, bit 1 wash, bit 2 park, bit 3 over-current |
| cleanOut | output | 4 | Debounced levels, same bit order |
| changePulse | output | 4 | One-cycle pulse per accepted change, same bit order |

## Verification
A wrong counter or a wrong prescaler tap shows at the ports as a clean level that moves early or late. That is visible at the first edge that falls outside the channel's window, at most 128 oscillator cycles after the input settled. A counter that is not cleared on a bounce shows as early acceptance after a glitch train. A stuck clean register or a missing pulse is caught at the very edge where the change was due. The reference model measures elapsed oscillator cycles from the synchronised input. It therefore flags every acceptance outside its window at any prescaler phase, including inputs that change while the strobe is paused.

// File: rtl/wiperDebouncePkg.sv
package wiperDebouncePkg;

  localparam int NUM_CH      = 4;
  localparam int MAX_DIV_LOG = 4;
  localparam int CNT_W       = 4;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic                   oscTick;
    logic [MAX_DIV_LOG:0]   coarse;   // coarse[k]: tick of a divide-by-2^k tap
  } tickStrobes_t;

  // prescaler tap and tick count used when the clean level goes 0 -> 1
  function automatic int riseDivLog(input int ch);
    case (ch)
      0: return 3;
      1: return 4;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int riseCount(input int ch);
    case (ch)
      0: return 4;
      1: return 8;
      2: return 4;
      default: return 3;
    endcase
  endfunction

  // tap and count used when the clean level goes 1 -> 0
  function automatic int fallDivLog(input int ch);
    case (ch)
      0: return 3;
      1: return 4;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int fallCount(input int ch);
    case (ch)
      0: return 4;
      1: return 2;
      2: return 4;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/wiperDebounceCtrl.sv
module wiperDebounceCtrl
  import wiperDebouncePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         oscTick,
  output tickStrobes_t strobes
);

  logic [MAX_DIV_LOG-1:0] presc;
  logic [MAX_DIV_LOG:0]   coarseVec;

  // free-running prescaler, advanced only by oscillator cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        presc <= '0;
    else if (oscTick) presc <= presc + 1'b1;
  end

  assign coarseVec[0] = oscTick;

  for (genvar k = 1; k <= MAX_DIV_LOG; k++) begin : g_tap
    assign coarseVec[k] = oscTick & (&presc[k-1:0]);
  end

  always_comb begin
    strobes.oscTick = oscTick;
    strobes.coarse  = coarseVec;
  end

endmodule

// File: rtl/wiperDebounceChannel.sv
module wiperDebounceChannel
  import wiperDebouncePkg::*;
#(
  parameter int RISE_LOG = 0,
  parameter int RISE_N   = 3,
  parameter int FALL_LOG = 0,
  parameter int FALL_N   = 3,
  parameter int W        = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 syncIn,
  input  logic [MAX_DIV_LOG:0] coarse,
  output logic                 cleanLvl,
  output logic                 changeStrobe
);

  localparam logic [W-1:0] RISE_LAST = W'(RISE_N - 1);
  localparam logic [W-1:0] FALL_LAST = W'(FALL_N - 1);

  logic [W-1:0] cnt;
  logic         differs;
  logic         tick;
  logic         atLast;

  always_comb begin
    differs = syncIn != cleanLvl;
    tick    = cleanLvl ? coarse[FALL_LOG] : coarse[RISE_LOG];
    atLast  = cleanLvl ? (cnt == FALL_LAST) : (cnt == RISE_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      cleanLvl     <= 1'b0;
      changeStrobe <= 1'b0;
    end else begin
      changeStrobe <= 1'b0;
      if (!differs) begin
        cnt <= '0;
      end else if (tick) begin
        if (atLast) begin
          cleanLvl     <= syncIn;
          changeStrobe <= 1'b1;
          cnt          <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wiperDebounceDatapath.sv
module wiperDebounceDatapath
  import wiperDebouncePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIn,
  input  tickStrobes_t      strobes,
  output logic [NUM_CH-1:0] cleanOut,
  output logic [NUM_CH-1:0] changePulse
);

  logic [NUM_CH-1:0] metaStage;
  logic [NUM_CH-1:0] syncStage;

  // two-stage synchroniser, left without reset
  always_ff @(posedge clk) begin
    metaStage <= rawIn;
    syncStage <= metaStage;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wiperDebounceChannel #(
      .RISE_LOG (riseDivLog(ch)),
      .RISE_N   (riseCount(ch)),
      .FALL_LOG (fallDivLog(ch)),
      .FALL_N   (fallCount(ch)),
      .W        (CNT_W)
    ) chan_i (
      .clk          (clk),
      .rstN         (rstN),
      .syncIn       (syncStage[ch]),
      .coarse       (strobes.coarse),
      .cleanLvl     (cleanOut[ch]),
      .changeStrobe (changePulse[ch])
    );
  end

endmodule

// File: rtl/wiperDebounceTop.sv
module wiperDebounceTop
  import wiperDebouncePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic [NUM_CH-1:0] rawIn,
  output logic [NUM_CH-1:0] cleanOut,
  output logic [NUM_CH-1:0] changePulse
);

  tickStrobes_t strobes;

  wiperDebounceCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .oscTick (oscTick),
    .strobes (strobes)
  );

  wiperDebounceDatapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rawIn       (rawIn),
    .strobes     (strobes),
    .cleanOut    (cleanOut),
    .changePulse (changePulse)
  );

endmodule

// File: rtl/wiperDebounceChecker.sv
module wiperDebounceChecker
  import wiperDebouncePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              oscTick,
  input logic [NUM_CH-1:0] rawIn,
  input logic [NUM_CH-1:0] cleanOut,
  input logic [NUM_CH-1:0] changePulse
);

  // R9
  pulse_matches_chk: assert property (@(posedge clk) disable iff (!rstN)
    changePulse == (cleanOut ^ $past(cleanOut)));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(cleanOut));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_src
    // R2
    sync_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cleanOut[ch] != $past(cleanOut[ch])) |-> (cleanOut[ch] == $past(rawIn[ch], 3)));
  end

  // R7
  oc_min_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut[3] != $past(cleanOut[3])) |->
      ($past(rawIn[3], 4) == cleanOut[3]) && ($past(rawIn[3], 5) == cleanOut[3]));

endmodule

bind wiperDebounceTop wiperDebounceChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .oscTick     (oscTick),
  .rawIn       (rawIn),
  .cleanOut    (cleanOut),
  .changePulse (changePulse)
);

// File: tb/wiperDebounceTop_tb_top.sv
module wiperDebounceTop_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       oscTick = 1'b0;
  logic [3:0] rawIn = 4'b0;
  logic [3:0] cleanOut;
  logic [3:0] changePulse;

  int  errors = 0;
  int  checks = 0;
  int  gap = 3;
  int  gapCnt = 0;
  bit  tickRun = 1'b1;
  bit  finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wiperDebounceTop dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .oscTick     (oscTick),
    .rawIn       (rawIn),
    .cleanOut    (cleanOut),
    .changePulse (changePulse)
  );

  // acceptance windows in oscillator cycles, taken from the requirements
  function automatic int winLo(input int ch, input bit toHigh);
    case (ch)
      0: return 25;
      1: return toHigh ? 113 : 17;
      2: return 7;
      default: return 3;
    endcase
  endfunction

  function automatic int winHi(input int ch, input bit toHigh);
    case (ch)
      0: return 32;
      1: return toHigh ? 128 : 32;
      2: return 8;
      default: return 3;
    endcase
  endfunction

  function automatic string reqTag(input int ch, input bit toHigh);
    case (ch)
      0: return "R3";
      1: return toHigh ? "R4" : "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // oscillator strobe generator
  always @(negedge clk) begin
    if (!tickRun) begin
      oscTick = 1'b0;
      gapCnt  = 0;
    end else begin
      gapCnt++;
      if (gapCnt >= gap) begin
        oscTick = 1'b1;
        gapCnt  = 0;
      end else begin
        oscTick = 1'b0;
      end
    end
  end

  // reference model: captures inputs at the edge, judges outputs after it
  logic [3:0] edgeRaw = 4'b0;
  bit         edgeTick = 1'b0;
  bit         edgeRst = 1'b0;
  logic [3:0] q1 = 4'b0;
  logic [3:0] q2 = 4'b0;
  logic [3:0] seen;
  logic [3:0] refClean = 4'b0;
  int         elapsed [4];

  always @(posedge clk) begin
    edgeRaw  = rawIn;
    edgeTick = oscTick;
    edgeRst  = rstN;
  end

  always @(negedge clk) begin
    seen = q2;
    q2   = q1;
    q1   = edgeRaw;
    if (!edgeRst) begin
      refClean = 4'b0;
      for (int ch = 0; ch < 4; ch++) elapsed[ch] = 0;
      if (clk === 1'b0 && $time > 3)
        check(cleanOut == 4'b0 && changePulse == 4'b0, "R1", "outputs during reset",
              int'({cleanOut, changePulse}), 0);
    end else begin
      for (int ch = 0; ch < 4; ch++) begin
        bit toHigh;
        bit moved;
        int lo;
        int hi;
        toHigh = !refClean[ch];
        lo     = winLo(ch, toHigh);
        hi     = winHi(ch, toHigh);
        if (seen[ch] == refClean[ch]) elapsed[ch] = 0;
        else if (edgeTick) elapsed[ch]++;
        moved = cleanOut[ch] != refClean[ch];
        if (moved) begin
          check(seen[ch] != refClean[ch] && edgeTick && elapsed[ch] >= lo && elapsed[ch] <= hi,
                reqTag(ch, toHigh),
                $sformatf("R2 ch%0d accepted outside %0d..%0d cycles", ch, lo, hi),
                elapsed[ch], hi);
          refClean[ch] = cleanOut[ch];
          elapsed[ch]  = 0;
        end else if (seen[ch] != refClean[ch] && elapsed[ch] >= hi) begin
          check(1'b0, reqTag(ch, toHigh),
                $sformatf("R8 ch%0d not accepted by %0d cycles", ch, hi), elapsed[ch], hi);
          elapsed[ch] = 0;
        end
        check(changePulse[ch] == moved, "R9", $sformatf("ch%0d change pulse", ch),
              int'(changePulse[ch]), int'(moved));
      end
    end
  end

  task automatic settle();
    repeat (140 * gap + 10) @(negedge clk);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cleanOut == 4'b0, "R1", "clean levels after reset", int'(cleanOut), 0);

    // window sweep over prescaler phases and strobe spacings
    for (int ch = 0; ch < 4; ch++) begin
      for (int ph = 0; ph < 5; ph++) begin
        gap = 1 + (ph % 4);
        repeat (ph * 3 + 1) @(negedge clk);
        rawIn[ch] = 1'b1;
        settle();
        check(cleanOut[ch] == 1'b1, reqTag(ch, 1'b1), "level taken after window",
              int'(cleanOut[ch]), 1);
        repeat (ph * 5 + 2) @(negedge clk);
        rawIn[ch] = 1'b0;
        settle();
        check(cleanOut[ch] == 1'b0, reqTag(ch, 1'b0), "release taken after window",
              int'(cleanOut[ch]), 0);
      end
    end

    // R8: park bouncing shorter than its window
    gap = 2;
    for (int b = 0; b < 6; b++) begin
      rawIn[2] = 1'b1;
      repeat (4 + b) @(negedge clk);
      rawIn[2] = 1'b0;
      repeat (2) @(negedge clk);
    end
    check(cleanOut[2] == 1'b0, "R8", "park bounce rejected", int'(cleanOut[2]), 0);
    rawIn[2] = 1'b1;
    settle();
    check(cleanOut[2] == 1'b1, "R6", "park taken after bounce", int'(cleanOut[2]), 1);
    rawIn[2] = 1'b0;
    settle();

    // R8: interval glitch restarts the count
    gap = 1;
    rawIn[0] = 1'b1;
    repeat (20) @(negedge clk);
    rawIn[0] = 1'b0;
    @(negedge clk);
    rawIn[0] = 1'b1;
    repeat (20) @(negedge clk);
    check(cleanOut[0] == 1'b0, "R8", "interval count restarted", int'(cleanOut[0]), 0);
    settle();
    check(cleanOut[0] == 1'b1, "R3", "interval taken after restart", int'(cleanOut[0]), 1);
    rawIn[0] = 1'b0;
    settle();

    // R7: over-current spike of two cycles is rejected
    rawIn[3] = 1'b1;
    repeat (2) @(negedge clk);
    rawIn[3] = 1'b0;
    repeat (10) @(negedge clk);
    check(cleanOut[3] == 1'b0, "R7", "short over-current rejected", int'(cleanOut[3]), 0);

    // R10: no strobe, no progress
    gap = 2;
    tickRun = 1'b0;
    rawIn[2] = 1'b1;
    repeat (100) @(negedge clk);
    check(cleanOut[2] == 1'b0, "R10", "held without strobe", int'(cleanOut[2]), 0);
    tickRun = 1'b1;
    settle();
    check(cleanOut[2] == 1'b1, "R10", "taken once strobe resumes", int'(cleanOut[2]), 1);
    rawIn[2] = 1'b0;
    settle();

    // all channels together
    gap = 3;
    rawIn = 4'b1111;
    settle();
    check(cleanOut == 4'b1111, "R4", "all channels set", int'(cleanOut), 15);
    rawIn = 4'b0000;
    settle();
    check(cleanOut == 4'b0000, "R5", "all channels clear", int'(cleanOut), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule